// File: doc/BRIEF.md
# Dual Halfword Multiply-Accumulate Unit

This block treats each 32-bit operand as a pair of signed 16-bit halves (low half in bits 15:0, high half in bits 31:16). It multiplies the halves pairwise into two full-width products, then adds the products together or subtracts the second from the first. The halves of operand b can be crossed before the multiply, so that each half of a meets the opposite half of b. A third 32-bit operand c can then be added to the combined products as an accumulator term.

The result is registered once and wraps modulo 2^32; it is never saturated. A sticky overflow flag records any signed 32-bit overflow seen in either addition step. It stays set until a dedicated clear input or reset. A one-cycle output strobe marks each new result.

Top module: `dmac_unit`

## Requirements
- R1: While rst_ni is low, result_o is 0, q_o is 0 and valid_o is 0.
- R2: With sub_i=0, xchg_i=0 and acc_i=0, the result is a[15:0]*b[15:0] + a[31:16]*b[31:16], with every half read as a signed 16-bit value.
- R3: With xchg_i=1, the product pairs are crossed: a[15:0]*b[31:16] forms the first product and a[31:16]*b[15:0] the second.
- R4: With sub_i=1, the second product is subtracted from the first instead of added.
- R5: With acc_i=1, c_i is added as a signed 32-bit value after the products are combined. With acc_i=0, c_i has no effect on result_o or q_o.
- R6: result_o and q_o take the new values at the first rising edge where valid_i is high, and valid_o is high for exactly the cycle after each such edge. When valid_i is low, result_o holds its value.
- R7: On overflow the result is the low 32 bits of the exact value, with no saturation.
- R8: q_o is set when combining the two products overflows a signed 32-bit value.
- R9: q_o is set when adding c_i to the already wrapped product combination overflows a signed 32-bit value, even if the first step did not overflow.
- R10: q_o is sticky. No operation clears it. A cycle with q_clr_i high clears it, unless the operation accepted in that same cycle overflows, in which case q_o stays set.
- R11: Subtracting the two products never sets q_o by itself, even with full-scale operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Accept the operation on this edge |
| sub_i | input | 1 | 1: subtract the second product; 0: add it |
| xchg_i | input | 1 | 1: cross the halves of b before multiplying |
| acc_i | input | 1 | 1: add c_i to the combined products |
| a_i | input | 32 | Operand a, two signed halves |
| b_i | input | 32 | Operand b, two signed halves |
| c_i | input | 32 | Signed accumulator operand |
| q_clr_i | input | 1 | Clear the sticky overflow flag |
| valid_o | output | 1 | New result in this cycle |
| result_o | output | 32 | Registered wrapped result |
| q_o | output | 1 | Sticky overflow flag |

## Verification
Several behaviours are checked by assertions on every cycle. The output strobe follows valid_i by one cycle, and the result holds while the unit is idle. The flag never drops unless clear is applied, and it is set by an overflow in either step. A product difference never overflows. Only the bench's scenarios can show that the arithmetic is right: the sign handling of each half, the crossed pairing, the exact wrapped values, and that c is ignored without accumulate. They also show the overflow corner cases at full scale, and how clear and overflow interact when both fall in the same cycle.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  typedef struct packed {
    logic sub;
    logic xchg;
    logic acc;
  } dmac_op_t;
endpackage

// File: rtl/dmac_prod.sv
module dmac_prod #(
  parameter int HALF_W = 16,
  localparam int W = 2 * HALF_W
) (
  input  logic [W-1:0]        a_i,
  input  logic [W-1:0]        b_i,
  input  logic                xchg_i,
  output logic [1:0][W-1:0]   prod_o
);
  for (genvar k = 0; k < 2; k++) begin : g_lane
    logic [HALF_W-1:0]   ah, bh;
    logic signed [W-1:0] ax, bx;
    assign ah = a_i[k*HALF_W +: HALF_W];
    // crossed pairing takes the opposite half of b
    assign bh = xchg_i ? b_i[(1-k)*HALF_W +: HALF_W] : b_i[k*HALF_W +: HALF_W];
    assign ax = {{HALF_W{ah[HALF_W-1]}}, ah};
    assign bx = {{HALF_W{bh[HALF_W-1]}}, bh};
    assign prod_o[k] = ax * bx;
  end
endmodule

// File: rtl/dmac_combine.sv
module dmac_combine #(
  parameter int W = 32
) (
  input  logic [1:0][W-1:0] prod_i,
  input  logic [W-1:0]      c_i,
  input  logic              sub_i,
  input  logic              acc_i,
  output logic [W-1:0]      result_o,
  output logic              ovf_sum_o,
  output logic              ovf_acc_o
);
  logic [W:0]   p0_x, p1_x, c_x, s1, s2;
  logic [W-1:0] w1;

  assign p0_x = {prod_i[0][W-1], prod_i[0]};
  assign p1_x = {prod_i[1][W-1], prod_i[1]};
  assign c_x  = {c_i[W-1], c_i};

  assign s1        = sub_i ? (p0_x - p1_x) : (p0_x + p1_x);
  assign ovf_sum_o = s1[W] ^ s1[W-1];
  assign w1        = s1[W-1:0];

  // accumulate on the wrapped first-step value
  assign s2        = {w1[W-1], w1} + (acc_i ? c_x : '0);
  assign ovf_acc_o = s2[W] ^ s2[W-1];
  assign result_o  = s2[W-1:0];
endmodule

// File: rtl/dmac_unit.sv
module dmac_unit #(
  parameter int HALF_W = 16,
  localparam int W = 2 * HALF_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic         sub_i,
  input  logic         xchg_i,
  input  logic         acc_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  input  logic         q_clr_i,
  output logic         valid_o,
  output logic [W-1:0] result_o,
  output logic         q_o
);
  import dmac_pkg::*;

  dmac_op_t           op;
  logic [1:0][W-1:0]  prod;
  logic [W-1:0]       res_d;
  logic               ovf_sum, ovf_acc;
  logic [W-1:0]       result_q;
  logic               valid_q, q_q;

  assign op = '{sub: sub_i, xchg: xchg_i, acc: acc_i};

  dmac_prod #(.HALF_W(HALF_W)) i_prod (
    .a_i    (a_i),
    .b_i    (b_i),
    .xchg_i (op.xchg),
    .prod_o (prod)
  );

  dmac_combine #(.W(W)) i_combine (
    .prod_i    (prod),
    .c_i       (c_i),
    .sub_i     (op.sub),
    .acc_i     (op.acc),
    .result_o  (res_d),
    .ovf_sum_o (ovf_sum),
    .ovf_acc_o (ovf_acc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_q <= '0;
      valid_q  <= 1'b0;
      q_q      <= 1'b0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) result_q <= res_d;
      // new overflow wins over a same-cycle clear
      q_q <= (q_q & ~q_clr_i) | (valid_i & (ovf_sum | ovf_acc));
    end
  end

  assign result_o = result_q;
  assign valid_o  = valid_q;
  assign q_o      = q_q;

  p_sub_no_ovf_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && sub_i |-> !ovf_sum);
  p_strobe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  p_no_strobe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o));
  p_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_o && !q_clr_i |=> q_o);
  p_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_clr_i && !(valid_i && (ovf_sum || ovf_acc)) |=> !q_o);
  p_sum_ovf_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && ovf_sum |=> q_o);
  p_acc_ovf_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && ovf_acc |=> q_o);
endmodule

// File: tb/test_dmac_unit.sv
module test_dmac_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0, sub_i = 1'b0, xchg_i = 1'b0, acc_i = 1'b0, q_clr_i = 1'b0;
  logic [31:0] a_i = '0, b_i = '0, c_i = '0;
  logic        valid_o, q_o;
  logic [31:0] result_o;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dmac_unit i_dmac_unit (
    .clk_i, .rst_ni, .valid_i, .sub_i, .xchg_i, .acc_i,
    .a_i, .b_i, .c_i, .q_clr_i, .valid_o, .result_o, .q_o
  );

  typedef struct {
    logic [31:0] res;
    logic        q;
    string       tag;
  } exp_t;

  exp_t sb[$];
  int   n_tests = 0;
  int   n_fail  = 0;
  logic q_model = 1'b0;

  function automatic void chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endfunction

  // driver: expected values are hand-derived from the requirements
  task automatic op(input logic [31:0] a, b, c, input logic s, x, ac, cl,
                    input logic [31:0] exp_res, input logic exp_ovf, input string tag);
    exp_t e;
    q_model = (q_model & ~cl) | exp_ovf;
    e.res = exp_res; e.q = q_model; e.tag = tag;
    sb.push_back(e);
    a_i = a; b_i = b; c_i = c; sub_i = s; xchg_i = x; acc_i = ac; q_clr_i = cl;
    valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0; q_clr_i = 1'b0;
  endtask

  task automatic clear_q(input string tag);
    q_clr_i = 1'b1;
    @(negedge clk_i);
    q_clr_i = 1'b0;
    q_model = 1'b0;
    chk({tag, " q after clear"}, {31'b0, q_o}, 32'd0);
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (rst_ni && valid_o) begin
      if (sb.size() == 0) begin
        n_tests++; n_fail++;
        $display("FAIL R6: actual unexpected strobe expected none");
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk({e.tag, " result"}, result_o, e.res);
        chk({e.tag, " q"}, {31'b0, q_o}, {31'b0, e.q});
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    chk("R1 result", result_o, 32'd0);
    chk("R1 q", {31'b0, q_o}, 32'd0);
    chk("R1 valid", {31'b0, valid_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    op(32'h0002_0001, 32'h0004_0005, 32'd0, 0, 0, 0, 0, 32'd13,       0, "R2 plain add");
    op(32'h0002_0001, 32'h0004_0005, 32'd0, 0, 1, 0, 0, 32'd14,       0, "R3 crossed add");
    op(32'h0002_0001, 32'h0004_0005, 32'd0, 1, 0, 0, 0, 32'hFFFFFFFD, 0, "R4 sub");
    op(32'h0002_0001, 32'h0004_0005, 32'd0, 1, 1, 0, 0, 32'hFFFFFFFA, 0, "R4 R3 crossed sub");
    op(32'h0002_0001, 32'h0004_0003, 32'd10, 0, 0, 1, 0, 32'd21,      0, "R5 add acc");
    op(32'h0002_0001, 32'h0004_0003, 32'd10, 1, 0, 1, 0, 32'd5,       0, "R5 sub acc");
    op(32'h0002_0001, 32'h0004_0005, 32'h7FFFFFFF, 0, 0, 0, 0, 32'd13, 0, "R5 c ignored");
    op(32'hFFFE_0003, 32'h0005_FFF9, 32'd0, 0, 0, 0, 0, 32'hFFFFFFE1, 0, "R2 signed halves");

    repeat (3) @(negedge clk_i);
    chk("R6 hold result", result_o, 32'hFFFFFFE1);
    chk("R6 idle strobe", {31'b0, valid_o}, 32'd0);

    op(32'h8000_8000, 32'h7FFF_8000, 32'd0, 1, 0, 0, 0, 32'h7FFF8000, 0, "R11 full-scale sub");
    op(32'h8000_8000, 32'h8000_8000, 32'd0, 0, 0, 0, 0, 32'h80000000, 1, "R8 R7 sum overflow");
    op(32'h0002_0001, 32'h0004_0005, 32'd0, 0, 0, 0, 0, 32'd13,       0, "R10 sticky");
    @(negedge clk_i);
    clear_q("R10");

    op(32'h7FFF_7FFF, 32'h7FFF_7FFF, 32'h7FFFFFFF, 0, 0, 1, 0, 32'hFFFE0001, 1, "R9 acc overflow");
    op(32'h8000_8000, 32'h8000_8000, 32'd0, 0, 0, 0, 1, 32'h80000000, 1, "R10 clear with overflow");
    @(negedge clk_i);
    clear_q("R10 second");

    op(32'h0000_7FFF, 32'h0000_8000, 32'h80000000, 1, 0, 1, 0, 32'h40008000, 1, "R9 R7 acc underflow");
    @(negedge clk_i);

    repeat (2) @(negedge clk_i);
    chk("R6 scoreboard drained", sb.size(), 32'd0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule